// File: doc/BRIEF.md
# Status Ring Writer

This block produces fixed-size status entries into a circular ring held in on-chip memory. Each entry is eight 32-bit words. An upstream unit offers a finished status record on a valid/ready input. The block takes it, fills in a per-instance ring identifier and a wrap-generation count, and writes the words into the ring one per cycle. It then publishes the new head position.

A consumer reads the ring through a registered read port and returns its tail position as an input. The generation count starts at 1 on the first pass around the ring. It steps each time the writer wraps from the last slot back to slot 0. Because memory is cleared to zero before the first entry, a consumer can compare the low bit of the count in a slot with the bit it expects for the current pass. This tells it whether the slot holds a new entry without reading the head output.

The ring never overruns the consumer. At most DEPTH-1 entries can be outstanding, and intake stalls while the ring is full.

Top module: `status_ring_writer`

## Requirements
- R1: After reset, headPtr is 0 and initDone and recReady are 0. The block then writes zero into every ring word, one word per cycle over DEPTH*8 cycles, and raises initDone, which stays high until the next reset. After that, every ring word reads as 0, so every slot holds a generation count of 0.
- R2: recReady is 1 only when all of these hold: initDone is 1, no record is being written, and (headPtr+1) mod DEPTH differs from tailPtr. While the ring is full, an offered record is not taken and headPtr does not move.
- R3: The record accepted at a handshake is written to slot headPtr. Word w is taken from recData[32*w+31:32*w] and stored at ring word address headPtr*8+w. Words 0 to 4 are stored unchanged. The record is captured at the handshake, so later changes to recData do not alter it.
- R4: In word 5, bits [31:24] are stored as 0 and bits [23:0] come from the input. Word 6 is stored as all zeros, whatever the input holds.
- R5: Word 7 is stored as {generation count in bits [31:28], RING_ID in bits [27:20], zeros in bits [19:0]}. The input's word 7 has no effect.
- R6: Entries written on the first pass carry a generation count of 1. The count rises by one each time the write position wraps from slot DEPTH-1 to slot 0, and it continues at 0 after 15.
- R7: headPtr stays unchanged while the eight words of an entry are being written. It advances by one (mod DEPTH) on the clock edge that writes word 7, which is the 8th edge after the handshake edge.
- R8: rdData presents the ring word at rdAddr one clock after rdAddr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| recValid | input | 1 | A status record is offered |
| recReady | output | 1 | The offered record is taken on this edge |
| recData | input | 256 | Record, word w in bits [32w+31:32w] |
| tailPtr | input | log2(DEPTH) | Consumer tail slot |
| headPtr | output | log2(DEPTH) | Next slot to be written, for entries that are complete |
| initDone | output | 1 | The ring clear has finished |
| rdAddr | input | log2(DEPTH)+3 | Read word address (slot*8+word) |
| rdData | output | 32 | Read data, one cycle after rdAddr |

## Verification
The main path is tried with four record patterns: all ones, all zeros, an alternating pattern and distinct words. All ones shows that the reserved and stamped fields are forced and not passed through. All zeros shows that the identifier and count are inserted rather than left as zero. Distinct words expose any swapped or shifted word addressing.

A run with the tail held fixed fills the ring to its DEPTH-1 limit across a wrap. This separates a correct full test from off-by-one variants and shows the count step to 2. A long run with a tail that keeps pace with the head drives the count through 15 and back to 0.

// File: rtl/statring_pkg.sv
package statring_pkg;
  localparam int WORD_W    = 32;
  localparam int REC_WORDS = 8;
  localparam int SEL_W     = $clog2(REC_WORDS);
  localparam int LOOP_W    = 4;
  localparam int ID_W      = 8;
  localparam int REC_W     = WORD_W * REC_WORDS;

  typedef struct packed {
    logic             clrWr;
    logic             recLoad;
    logic             wordWr;
    logic [SEL_W-1:0] wordSel;
  } ring_strobe_t;
endpackage

// File: rtl/statring_ctrl.sv
module statring_ctrl
  import statring_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = IDX_W + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recValid,
  input  logic [IDX_W-1:0]  tailPtr,
  output logic              recReady,
  output logic [IDX_W-1:0]  headPtr,
  output logic              initDone,
  output logic [LOOP_W-1:0] loopCnt,
  output ring_strobe_t      strobe,
  output logic [ADDR_W-1:0] memAddr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH * REC_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(DEPTH - 1);
  localparam logic [SEL_W-1:0]  LAST_WORD = SEL_W'(REC_WORDS - 1);

  typedef enum logic [1:0] {ST_CLEAR, ST_IDLE, ST_WRITE} ctrl_state_e;

  ctrl_state_e      state;
  logic [ADDR_W-1:0] clrCnt;
  logic [SEL_W-1:0]  wordIdx;
  logic              ringFull;
  logic              accept;

  assign ringFull = (IDX_W'(headPtr + 1'b1) == tailPtr);
  assign recReady = (state == ST_IDLE) && !ringFull;
  assign accept   = recValid && recReady;
  assign initDone = (state != ST_CLEAR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_CLEAR;
      clrCnt  <= '0;
      wordIdx <= '0;
      headPtr <= '0;
      loopCnt <= LOOP_W'(1);
    end else begin
      case (state)
        ST_CLEAR: begin
          clrCnt <= clrCnt + 1'b1;
          if (clrCnt == LAST_ADDR) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_WRITE;
            wordIdx <= '0;
          end
        end
        ST_WRITE: begin
          wordIdx <= wordIdx + 1'b1;
          if (wordIdx == LAST_WORD) begin
            state   <= ST_IDLE;
            headPtr <= headPtr + 1'b1;
            if (headPtr == LAST_SLOT) loopCnt <= loopCnt + 1'b1;
          end
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end

  always_comb begin
    strobe.clrWr   = (state == ST_CLEAR);
    strobe.recLoad = accept;
    strobe.wordWr  = (state == ST_WRITE);
    strobe.wordSel = wordIdx;
    memAddr        = (state == ST_CLEAR) ? clrCnt : {headPtr, wordIdx};
  end

  // R7
  head_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(headPtr) |-> headPtr == IDX_W'($past(headPtr) + 1'b1));

  // R6
  loop_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(loopCnt) |-> (headPtr == '0) && ($past(headPtr) == LAST_SLOT));

  // R1
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R2
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recReady) |=> !recReady);
endmodule

// File: rtl/statring_dpath.sv
module statring_dpath
  import statring_pkg::*;
#(
  parameter int             DEPTH   = 16,
  parameter logic [ID_W-1:0] RING_ID = 8'h3C,
  parameter int             IDX_W   = $clog2(DEPTH),
  parameter int             ADDR_W  = IDX_W + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REC_W-1:0]  recData,
  input  ring_strobe_t      strobe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [LOOP_W-1:0] loopCnt,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  localparam int RING_WORDS = DEPTH * REC_WORDS;
  localparam int PASS_WORDS = 5;
  localparam int W5_KEEP    = 24;
  localparam int RSV7_W     = WORD_W - LOOP_W - ID_W;
  localparam int KEEP_W     = PASS_WORDS * WORD_W + W5_KEEP;

  logic [KEEP_W-1:0]       recBuf;
  logic [WORD_W-1:0]       recWord [PASS_WORDS];
  logic [WORD_W-1:0]       stampWord;
  logic [WORD_W-1:0]       memWrData;
  logic                    memWrEn;
  logic [WORD_W-1:0]       ringMem [RING_WORDS];
  logic                    unusedRecBits;

  assign unusedRecBits = ^recData[REC_W-1:KEEP_W];

  always_ff @(posedge clk) begin
    if (strobe.recLoad) recBuf <= recData[KEEP_W-1:0];
  end

  for (genvar w = 0; w < PASS_WORDS; w++) begin : g_pass
    assign recWord[w] = recBuf[w*WORD_W +: WORD_W];
  end

  always_comb begin
    case (strobe.wordSel)
      SEL_W'(5): stampWord = {{(WORD_W-W5_KEEP){1'b0}}, recBuf[KEEP_W-1 -: W5_KEEP]};
      SEL_W'(6): stampWord = '0;
      SEL_W'(7): stampWord = {loopCnt, RING_ID, {RSV7_W{1'b0}}};
      default:   stampWord = recWord[strobe.wordSel];
    endcase
  end

  assign memWrEn   = strobe.clrWr || strobe.wordWr;
  assign memWrData = strobe.clrWr ? '0 : stampWord;

  always_ff @(posedge clk) begin
    if (memWrEn) ringMem[memAddr] <= memWrData;
    rdData <= ringMem[rdAddr];
  end

  // R4
  rsv_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && memAddr[SEL_W-1:0] == SEL_W'(6)) |-> memWrData == '0);

  // R5
  stamp_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wordWr && memAddr[SEL_W-1:0] == SEL_W'(7)) |->
      (memWrData[WORD_W-1 -: LOOP_W] == loopCnt) && (memWrData[RSV7_W-1:0] == '0));
endmodule

// File: rtl/status_ring_writer.sv
module status_ring_writer
  import statring_pkg::*;
#(
  parameter int              DEPTH   = 16,
  parameter logic [ID_W-1:0] RING_ID = 8'h3C,
  parameter int              IDX_W   = $clog2(DEPTH),
  parameter int              ADDR_W  = IDX_W + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recValid,
  output logic              recReady,
  input  logic [REC_W-1:0]  recData,
  input  logic [IDX_W-1:0]  tailPtr,
  output logic [IDX_W-1:0]  headPtr,
  output logic              initDone,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  ring_strobe_t      strobe;
  logic [ADDR_W-1:0] memAddr;
  logic [LOOP_W-1:0] loopCnt;

  statring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .recValid(recValid), .tailPtr(tailPtr),
    .recReady(recReady), .headPtr(headPtr), .initDone(initDone),
    .loopCnt(loopCnt), .strobe(strobe), .memAddr(memAddr)
  );

  statring_dpath #(.DEPTH(DEPTH), .RING_ID(RING_ID), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .recData(recData), .strobe(strobe),
    .memAddr(memAddr), .loopCnt(loopCnt), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/status_ring_writer_bench.sv
module status_ring_writer_bench;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 3;
  localparam logic [7:0] RID = 8'hA5;
  localparam int NPAT = 4;
  localparam logic [31:0] PAT [NPAT][8] = '{
    '{8{32'hFFFF_FFFF}},
    '{8{32'h0000_0000}},
    '{8{32'hA5A5_5A5A}},
    '{32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003,
      32'h5555_0004, 32'h6666_0005, 32'h7777_0006, 32'h8888_0007}
  };

  logic clk = 0, rstN = 0, recValid = 0, recReady, initDone;
  logic [255:0] recData = '0;
  logic [IDX_W-1:0] tailPtr = '0, headPtr;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0] rdData;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [3:0] expLoop = 4'd1;
  logic [3:0] lastLoop;
  logic [IDX_W-1:0] lastSlot;

  always #4 clk = ~clk;

  status_ring_writer #(.DEPTH(DEPTH), .RING_ID(RID)) u_status_ring_writer (
    .clk(clk), .rstN(rstN), .recValid(recValid), .recReady(recReady),
    .recData(recData), .tailPtr(tailPtr), .headPtr(headPtr),
    .initDone(initDone), .rdAddr(rdAddr), .rdData(rdData));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int w, input logic [31:0] src, input logic [3:0] lp);
    case (w)
      5: return {8'h00, src[23:0]};
      6: return 32'h0;
      7: return {lp, RID, 20'h0};
      default: return src;
    endcase
  endfunction

  task automatic readWord(input int addr, output logic [31:0] data);
    @(negedge clk);
    rdAddr = ADDR_W'(addr);
    @(negedge clk);
    data = rdData;
  endtask

  task automatic sendRec(input logic [31:0] words [8]);
    logic [IDX_W-1:0] h0;
    @(negedge clk);
    for (int w = 0; w < 8; w++) recData[w*32 +: 32] = words[w];
    recValid = 1;
    while (!recReady) @(negedge clk);
    h0 = headPtr;
    @(negedge clk);
    recValid = 0;
    recData = {8{32'hDEAD_BEEF}};
    repeat (7) @(negedge clk);
    chk("R7 head held mid-write", 32'(headPtr), 32'(h0));
    @(negedge clk);
    chk("R7 head advanced", 32'(headPtr), 32'(IDX_W'(h0 + 1'b1)));
    lastSlot = h0;
    lastLoop = expLoop;
    if (h0 == IDX_W'(DEPTH - 1)) expLoop = expLoop + 1'b1;
  endtask

  task automatic checkSlot(input logic [IDX_W-1:0] slot, input logic [31:0] words [8], input logic [3:0] lp);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      readWord(int'(slot) * 8 + w, d);
      chk($sformatf("R3 R4 R5 R8 slot %0d word %0d", slot, w), d, expWord(w, words[w], lp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] wv [8];
    int n;
    repeat (3) @(negedge clk);
    chk("R1 head at reset", 32'(headPtr), 0);
    chk("R1 initDone at reset", 32'(initDone), 0);
    chk("R1 ready at reset", 32'(recReady), 0);
    rstN = 1;
    recValid = 1;
    repeat (60) @(negedge clk);
    chk("R1 R2 no intake during clear", 32'(recReady), 0);
    chk("R1 initDone low during clear", 32'(initDone), 0);
    recValid = 0;
    n = 0;
    while (!initDone) begin @(negedge clk); n++; end
    chk("R1 clear length", 32'(n + 60), 32'(DEPTH * 8));
    chk("R2 ready after clear", 32'(recReady), 1);
    for (int a = 0; a < DEPTH * 8; a++) begin
      readWord(a, d);
      chk($sformatf("R1 cleared word %0d", a), d, 0);
    end

    for (int p = 0; p < NPAT; p++) begin
      tailPtr = headPtr;
      for (int w = 0; w < 8; w++) wv[w] = PAT[p][w];
      sendRec(wv);
      checkSlot(lastSlot, wv, lastLoop);
    end

    tailPtr = headPtr;
    for (int r = 0; r < DEPTH - 1; r++) begin
      for (int w = 0; w < 8; w++) wv[w] = 32'h0BAD_0000 + 32'(r * 8 + w);
      sendRec(wv);
    end
    chk("R2 full at DEPTH-1 entries", 32'(recReady), 0);
    recValid = 1;
    repeat (20) @(negedge clk);
    chk("R2 head held while full", 32'(headPtr), 32'(IDX_W'(tailPtr - 1'b1)));
    chk("R2 still stalled", 32'(recReady), 0);
    recValid = 0;
    checkSlot(lastSlot, wv, lastLoop);
    readWord(7, d);
    chk("R6 second pass count", 32'(d[31:28]), 2);
    readWord((DEPTH - 1) * 8 + 7, d);
    chk("R6 first pass count", 32'(d[31:28]), 1);
    tailPtr = tailPtr + 1'b1;
    @(negedge clk);
    chk("R2 ready after tail moves", 32'(recReady), 1);

    n = 0;
    while (expLoop != 4'd0) begin
      tailPtr = headPtr;
      for (int w = 0; w < 8; w++) wv[w] = 32'h5000_0000 ^ 32'(n * 8 + w);
      sendRec(wv);
      n++;
    end
    readWord((DEPTH - 1) * 8 + 7, d);
    chk("R6 count reaches 15", 32'(d[31:28]), 15);
    tailPtr = headPtr;
    for (int w = 0; w < 8; w++) wv[w] = 32'hC0DE_0000 + 32'(w);
    sendRec(wv);
    chk("R6 wrapped slot", 32'(lastSlot), 0);
    checkSlot(lastSlot, wv, 4'd0);
    readWord(7, d);
    chk("R6 count 15 wraps to 0", 32'(d[31:28]), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule